// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the per-processor bookkeeping behind interrupt acknowledge and end-of-interrupt. It holds the interrupt that is being serviced, together with the priority that was latched when that interrupt was taken. It also holds a predecessor link for every interrupt, so that nested (preempted) interrupts form a chain. The chain lets service resume in the right order as each handler finishes.

An acknowledge request samples the highest-pending ID that an external selector supplies. The request succeeds only when that ID is real and its priority is strictly more urgent than the running priority. A successful acknowledge pushes the running interrupt behind the new one and asks for the new interrupt's pending bit to be cleared. A completion request names an interrupt:
- If it names the running interrupt, the predecessor of that interrupt is restored.
- If it names an interrupt deeper in the chain, a walker follows one link per cycle and splices that entry out. The block reports busy during the walk and ignores new requests until it ends.
- A completed level-sensitive interrupt whose line is still high, that is enabled and that is routed to this processor, produces a request to set its pending bit again.

States:
- `ST_IDLE`: accepts requests.
- `ST_WALK`: follows the chain.

Transitions:
- `ST_IDLE` to `ST_WALK` on an accepted completion of a non-running ID.
- `ST_WALK` to `ST_IDLE` when any one of these holds:
  - the next link is the spurious ID 1023 (end of chain);
  - the next link equals the completed ID (splice);
  - the walker has taken `NUM_IRQ` steps.

Top module: `ackt_tracker`

## Requirements
- R1: After reset `run_id` is 1023, `run_prio` is 0x100 (bit `PRIO_W` set, others clear), `busy` is 0, and `ack_valid`, `clr_pend_valid` and `set_pend_valid` are 0; every predecessor link holds 1023.
- R2: An acknowledge taken in `ST_IDLE` fails when `hp_id` is 1023, or when `hp_id` is at or above `NUM_IRQ`, or when the priority of `hp_id` is not strictly below `run_prio`. A failed acknowledge gives `ack_valid`=1 with `ack_id`=1023 one cycle later, and `run_id`, `run_prio` and the links stay as they were, with no clear request.
- R3: A successful acknowledge gives, one cycle later, `ack_valid`=1 and `ack_id`=`hp_id`, together with a one-cycle `clr_pend_valid` carrying `clr_pend_id`=`hp_id`. At the same time `run_id` becomes `hp_id` and `run_prio` becomes its 8-bit priority zero-extended and latched. The old `run_id` is stored as the new ID's predecessor.
- R4: Whenever `run_id` is 1023, `run_prio` is 0x100.
- R5: The completion ID is `eoi_data[9:0]`, and the upper bits are ignored. A completion of an ID at or above `NUM_IRQ` (1023 included) changes nothing and raises no set request.
- R6: A completion while `run_id` is 1023 changes nothing and raises no set request.
- R7: Completing the running ID makes its predecessor the running ID one cycle later. `run_prio` becomes that predecessor's priority as configured at the time of completion, or 0x100 for 1023.
- R8: Completing a non-running ID leaves `run_id` unchanged and holds `busy` for k cycles. Here k is the position of the ID in the chain counted from the running ID (1 for its direct predecessor), or the chain length if the ID is absent. A found ID is spliced out, so its predecessor takes its place in the chain.
- R9: An accepted completion (R5, R6 pass) of ID i gives a one-cycle `set_pend_valid` with `set_pend_id`=i one cycle later exactly when all of these hold: `trig_edge[i]`=0 (level-sensitive), `line_level[i]`=1, `irq_en[i]`=1 and `tgt_me[i]`=1.
- R10: While `busy` is 1, acknowledge and completion requests are ignored: no `ack_valid` and no state change.
- R11: When acknowledge and completion are requested in the same idle cycle, the acknowledge is served and the completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request, one cycle |
| hp_id | input | 10 | Highest-pending ID from the selector (1023 = none) |
| eoi_req | input | 1 | Completion request, one cycle |
| eoi_data | input | DATA_W | Completion write value; ID in bits 9:0 |
| prio_flat | input | NUM_IRQ*PRIO_W | Priority of ID i in bits i*PRIO_W +: PRIO_W |
| trig_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| line_level | input | NUM_IRQ | Current input line level |
| irq_en | input | NUM_IRQ | Interrupt enable |
| tgt_me | input | NUM_IRQ | Interrupt routed to this processor |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_id | output | 10 | Acknowledged ID, 1023 when none |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| clr_pend_valid | output | 1 | Request to clear a pending bit |
| clr_pend_id | output | 10 | ID whose pending bit to clear |
| set_pend_valid | output | 1 | Request to set a pending bit again |
| set_pend_id | output | 10 | ID whose pending bit to set |
| busy | output | 1 | Chain walk in progress |

## Verification
A corrupted predecessor link stays invisible until the interrupt above it is completed. At that point `run_id` and `run_prio` show the wrong interrupt one cycle after the completion, which may be many operations after the fault. A walker fault shows up sooner, as a `busy` pulse of the wrong length. A splice that misses its target shows up only when a later completion restores an interrupt that should have left the chain. For this reason the stimulus builds four-deep chains and unwinds them through mid-chain completions, absent IDs and priority changes, comparing every output on every cycle.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;
    typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_state_e;
endpackage

// File: rtl/ackt_prio_mux.sv
module ackt_prio_mux
    import ackt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [ID_W-1:0]           id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [PRIO_W:0]           prio_ext
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    // Out-of-range IDs (1023 included) read as the idle priority
    always_comb begin
        if (id < LIMIT) prio_ext = {1'b0, prio_arr[id[IDX_W-1:0]]};
        else            prio_ext = {1'b1, {PRIO_W{1'b0}}};
    end
endmodule

// File: rtl/ackt_link_table.sv
module ackt_link_table
    import ackt_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] rd_a_id,
    output logic [ID_W-1:0] rd_a_link,
    input  logic [ID_W-1:0] rd_b_id,
    output logic [ID_W-1:0] rd_b_link,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic [ID_W-1:0] wr_link
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0] links [NUM_IRQ];
    logic            wr_hit;

    assign wr_hit    = wr_en && (wr_id < LIMIT);
    assign rd_a_link = (rd_a_id < LIMIT) ? links[rd_a_id[IDX_W-1:0]] : SPUR_ID;
    assign rd_b_link = (rd_b_id < LIMIT) ? links[rd_b_id[IDX_W-1:0]] : SPUR_ID;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) links[i] <= SPUR_ID;
        end else if (wr_hit) begin
            links[wr_id[IDX_W-1:0]] <= wr_link;
        end
    end
endmodule

// File: rtl/ackt_repend.sv
module ackt_repend
    import ackt_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [ID_W-1:0]    id,
    input  logic [NUM_IRQ-1:0] trig_edge,
    input  logic [NUM_IRQ-1:0] line_level,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] tgt_me,
    output logic               hit
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [IDX_W-1:0] idx;
    assign idx = id[IDX_W-1:0];

    // Level-sensitive, line still high, enabled, routed here
    assign hit = (id < LIMIT) && !trig_edge[idx] && line_level[idx]
                 && irq_en[idx] && tgt_me[idx];
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker
    import ackt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req,
    input  logic [9:0]                hp_id,
    input  logic                      eoi_req,
    input  logic [DATA_W-1:0]         eoi_data,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ-1:0]        trig_edge,
    input  logic [NUM_IRQ-1:0]        line_level,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        tgt_me,
    output logic                      ack_valid,
    output logic [9:0]                ack_id,
    output logic [9:0]                run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      clr_pend_valid,
    output logic [9:0]                clr_pend_id,
    output logic                      set_pend_valid,
    output logic [9:0]                set_pend_id,
    output logic                      busy
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0]   LIMIT     = ID_W'(NUM_IRQ);
    localparam logic [IDX_W-1:0]  CNT_LAST  = IDX_W'(NUM_IRQ - 1);
    localparam logic [PRIO_W:0]   IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    walk_state_e     state_q, state_d;
    logic [ID_W-1:0] run_q, cur_q, tgt_q;
    logic [PRIO_W:0] rprio_q;
    logic [IDX_W-1:0] cnt_q;
    logic            ack_v_q, clr_v_q, set_v_q;
    logic [ID_W-1:0] ack_id_q, clr_id_q, set_id_q;

    logic            in_idle, in_walk, take_ack, take_eoi, ack_ok;
    logic            eoi_ok, eoi_top, walk_end, splice, rep_hit;
    logic [ID_W-1:0] eoi_id, link_a, link_b, rd_a_id, wr_id, wr_link;
    logic [PRIO_W:0] hp_prio, pop_prio;
    logic            unused_eoi_hi;

    assign unused_eoi_hi = ^eoi_data[DATA_W-1:ID_W];
    assign eoi_id   = eoi_data[ID_W-1:0];
    assign in_idle  = (state_q == ST_IDLE);
    assign in_walk  = (state_q == ST_WALK);
    assign take_ack = ack_req && in_idle;
    assign take_eoi = eoi_req && !ack_req && in_idle;
    assign ack_ok   = take_ack && (hp_prio < rprio_q);
    assign eoi_ok   = take_eoi && (eoi_id < LIMIT) && (run_q != SPUR_ID);
    assign eoi_top  = eoi_ok && (eoi_id == run_q);
    assign splice   = in_walk && (link_a == tgt_q);
    assign walk_end = (link_a == SPUR_ID) || (link_a == tgt_q) || (cnt_q == CNT_LAST);

    assign rd_a_id = in_walk ? cur_q : run_q;
    assign wr_id   = ack_ok ? hp_id : cur_q;
    assign wr_link = ack_ok ? run_q : link_b;

    ackt_prio_mux #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_prio_hp (
        .id(hp_id), .prio_flat(prio_flat), .prio_ext(hp_prio)
    );

    ackt_prio_mux #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_prio_pop (
        .id(link_a), .prio_flat(prio_flat), .prio_ext(pop_prio)
    );

    ackt_link_table #(.NUM_IRQ(NUM_IRQ)) u_links (
        .clk(clk), .rst_n(rst_n),
        .rd_a_id(rd_a_id), .rd_a_link(link_a),
        .rd_b_id(tgt_q),   .rd_b_link(link_b),
        .wr_en(ack_ok || splice), .wr_id(wr_id), .wr_link(wr_link)
    );

    ackt_repend #(.NUM_IRQ(NUM_IRQ)) u_repend (
        .id(eoi_id), .trig_edge(trig_edge), .line_level(line_level),
        .irq_en(irq_en), .tgt_me(tgt_me), .hit(rep_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (eoi_ok && !eoi_top) state_d = ST_WALK;
            ST_WALK: if (walk_end)           state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= SPUR_ID;
            rprio_q  <= IDLE_PRIO;
            cur_q    <= SPUR_ID;
            tgt_q    <= SPUR_ID;
            cnt_q    <= '0;
            ack_v_q  <= 1'b0;
            ack_id_q <= SPUR_ID;
            clr_v_q  <= 1'b0;
            clr_id_q <= SPUR_ID;
            set_v_q  <= 1'b0;
            set_id_q <= SPUR_ID;
        end else begin
            ack_v_q  <= take_ack;
            ack_id_q <= ack_ok ? hp_id : SPUR_ID;
            clr_v_q  <= ack_ok;
            clr_id_q <= ack_ok ? hp_id : SPUR_ID;
            set_v_q  <= eoi_ok && rep_hit;
            set_id_q <= eoi_id;
            if (ack_ok) begin
                run_q   <= hp_id;
                rprio_q <= hp_prio;
            end else if (eoi_top) begin
                run_q   <= link_a;
                rprio_q <= pop_prio;
            end
            if (eoi_ok && !eoi_top) begin
                cur_q <= run_q;
                tgt_q <= eoi_id;
                cnt_q <= '0;
            end else if (in_walk) begin
                cur_q <= link_a;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ack_valid      = ack_v_q;
    assign ack_id         = ack_id_q;
    assign run_id         = run_q;
    assign run_prio       = rprio_q;
    assign clr_pend_valid = clr_v_q;
    assign clr_pend_id    = clr_id_q;
    assign set_pend_valid = set_v_q;
    assign set_pend_id    = set_id_q;
    assign busy           = in_walk;
endmodule

// File: rtl/ackt_checker.sv
module ackt_checker
    import ackt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_req,
    input logic [9:0]      hp_id,
    input logic            eoi_req,
    input logic [9:0]      eoi_low,
    input logic            ack_valid,
    input logic [9:0]      ack_id,
    input logic [9:0]      run_id,
    input logic [PRIO_W:0] run_prio,
    input logic            clr_pend_valid,
    input logic [9:0]      clr_pend_id,
    input logic            set_pend_valid,
    input logic            busy
);
    localparam logic [9:0]      LIMIT     = 10'(NUM_IRQ);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    p_idle_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == SPUR_ID) |-> (run_prio == IDLE_PRIO));

    p_spurious_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy && hp_id == SPUR_ID) |=>
        (ack_valid && ack_id == SPUR_ID && $stable(run_id) && !clr_pend_valid));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != SPUR_ID) |->
        (clr_pend_valid && clr_pend_id == ack_id && run_id == ack_id));

    p_ack_raises_urgency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != SPUR_ID) |-> (run_prio < $past(run_prio)));

    p_eoi_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && !busy && run_id == SPUR_ID) |=>
        ($stable(run_id) && !busy && !set_pend_valid));

    p_eoi_out_of_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && !busy && eoi_low >= LIMIT) |=>
        ($stable(run_id) && !busy && !set_pend_valid));

    p_busy_drops_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_req) |=> !ack_valid);

    p_walk_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(eoi_req) && $stable(run_id)));

    p_ack_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && eoi_req && !busy) |=> (ack_valid && !set_pend_valid && !busy));
endmodule

bind ackt_tracker ackt_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_ackt_checker (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
    .eoi_req(eoi_req), .eoi_low(eoi_data[9:0]),
    .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
    .clr_pend_valid(clr_pend_valid), .clr_pend_id(clr_pend_id),
    .set_pend_valid(set_pend_valid), .busy(busy)
);

// File: tb/ackt_tracker_tb_top.sv
`timescale 1ns/1ps
module ackt_tracker_tb_top;
    localparam int N  = 64;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          ack_req = 1'b0, eoi_req = 1'b0;
    logic [9:0]    hp_id = 10'd1023;
    logic [31:0]   eoi_data = '0;
    logic [7:0]    p_arr [N];
    logic [N*PW-1:0] prio_flat;
    logic [N-1:0]  trig_edge, line_level, irq_en, tgt_me;
    logic          ack_valid, clr_pend_valid, set_pend_valid, busy;
    logic [9:0]    ack_id, run_id, clr_pend_id, set_pend_id;
    logic [PW:0]   run_prio;

    always_comb for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = p_arr[i];

    ackt_tracker #(.NUM_IRQ(N), .PRIO_W(PW), .DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
        .eoi_req(eoi_req), .eoi_data(eoi_data), .prio_flat(prio_flat),
        .trig_edge(trig_edge), .line_level(line_level), .irq_en(irq_en),
        .tgt_me(tgt_me), .ack_valid(ack_valid), .ack_id(ack_id),
        .run_id(run_id), .run_prio(run_prio), .clr_pend_valid(clr_pend_valid),
        .clr_pend_id(clr_pend_id), .set_pend_valid(set_pend_valid),
        .set_pend_id(set_pend_id), .busy(busy)
    );

    // Behavioural reference state
    int m_run, m_rprio, m_busy;
    int m_link [N];
    bit e_ackv, e_clrv, e_setv;
    int e_ackid, e_clrid, e_setid;
    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    function automatic int mprio(int id);
        return (id >= 0 && id < N) ? int'(p_arr[id]) : 256;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        e_ackv = 0; e_clrv = 0; e_setv = 0;
        if (!rst_n) begin
            m_run = 1023; m_rprio = 256; m_busy = 0;
            for (int i = 0; i < N; i++) m_link[i] = 1023;
        end else if (m_busy > 0) begin
            m_busy--;
        end else if (ack_req) begin
            int h = int'(hp_id);
            e_ackv = 1;
            if (h < N && mprio(h) < m_rprio) begin
                e_ackid = h; e_clrv = 1; e_clrid = h;
                m_link[h] = m_run; m_run = h; m_rprio = mprio(h);
            end else begin
                e_ackid = 1023;
            end
        end else if (eoi_req) begin
            int id = int'(eoi_data[9:0]);
            if (id < N && m_run != 1023) begin
                if (!trig_edge[id] && line_level[id] && irq_en[id] && tgt_me[id]) begin
                    e_setv = 1; e_setid = id;
                end
                if (id == m_run) begin
                    m_run = m_link[id];
                    m_rprio = mprio(m_run);
                end else begin
                    int t = m_run, k = 0, n;
                    forever begin
                        k++;
                        n = m_link[t];
                        if (n == 1023) break;
                        if (n == id) begin m_link[t] = m_link[id]; break; end
                        if (k == N) break;
                        t = n;
                    end
                    m_busy = k;
                end
            end
        end
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "busy", int'(busy), int'(m_busy > 0));
        chk(tag, "run_id", int'(run_id), m_run);
        chk(tag, "run_prio", int'(run_prio), m_rprio);
        chk(tag, "ack_valid", int'(ack_valid), int'(e_ackv));
        if (e_ackv) chk(tag, "ack_id", int'(ack_id), e_ackid);
        chk(tag, "clr_pend_valid", int'(clr_pend_valid), int'(e_clrv));
        if (e_clrv) chk(tag, "clr_pend_id", int'(clr_pend_id), e_clrid);
        chk(tag, "set_pend_valid", int'(set_pend_valid), int'(e_setv));
        if (e_setv) chk(tag, "set_pend_id", int'(set_pend_id), e_setid);
        ack_req = 1'b0;
        eoi_req = 1'b0;
    endtask

    task automatic do_ack(int id, string tag);
        ack_req = 1'b1; hp_id = 10'(id); cyc(tag);
    endtask

    task automatic do_eoi(logic [31:0] v, string tag);
        eoi_req = 1'b1; eoi_data = v; cyc(tag);
    endtask

    task automatic idle_until_free(string tag);
        for (int i = 0; i < 2 * N && m_busy > 0; i++) cyc(tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) p_arr[i] = 8'h80;
        p_arr[40] = 8'h60; p_arr[41] = 8'h50; p_arr[42] = 8'h40;
        p_arr[43] = 8'h30; p_arr[44] = 8'h30; p_arr[45] = 8'h10;
        trig_edge = '1; line_level = '0; irq_en = '1; tgt_me = '1;
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        cyc("R1");
        do_eoi(32'd40, "R6");             // completion with nothing running
        do_ack(1023, "R2");               // no pending interrupt
        do_ack(100, "R2");                // ID beyond implemented range
        do_ack(40, "R3"); do_ack(41, "R3"); do_ack(42, "R3"); do_ack(43, "R3");
        do_ack(44, "R2");                 // equal priority is not enough
        do_ack(41, "R2");                 // less urgent than running
        do_eoi(32'hFFFF_FFFF, "R5");      // low bits 1023
        do_eoi(32'd64, "R5");             // just past the range
        do_eoi(32'd40, "R8");             // deepest entry, three links
        do_ack(45, "R10");                // dropped while walking
        do_eoi(32'd43, "R10");            // dropped while walking
        idle_until_free("R8");
        do_eoi(32'd50, "R8");             // absent ID, walk to chain end
        idle_until_free("R8");
        p_arr[42] = 8'h48;                // priority changed after acknowledge
        cyc("R3");
        do_eoi(32'hABCD_0000 | 32'd43, "R7"); // pop, upper bits ignored
        trig_edge[42] = 1'b0; line_level[42] = 1'b1;
        do_eoi(32'd42, "R9");             // level still high: pending again
        trig_edge[41] = 1'b0; line_level[41] = 1'b1; tgt_me[41] = 1'b0;
        do_eoi(32'd41, "R9");             // not routed here: no set request
        cyc("R4");
        do_ack(40, "R3"); do_ack(41, "R3");
        trig_edge[40] = 1'b0; line_level[40] = 1'b1;
        do_eoi(32'd40, "R9");             // repend from a mid-chain completion
        idle_until_free("R8");
        ack_req = 1'b1; hp_id = 10'd45; eoi_req = 1'b1; eoi_data = 32'd41;
        cyc("R11");
        do_eoi(32'd45, "R7");
        do_eoi(32'd41, "R7");
        cyc("R4"); cyc("R4");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule